// File: doc/BRIEF.md
# Quad-Channel Alarm Interrupt Controller

This block collects per-channel alarm flags from a four-channel line interface and turns their changes into one host interrupt. There are three alarm sources: loss of signal, transmit driver failure and alarm indication signal. Each raw alarm passes through a synchroniser. Any change of a synchronised alarm, rising or falling, sets a sticky status bit for that source and channel. The host clears a status bit by writing 1 to it. A per-source, per-channel enable register decides which status bits pull the shared active-low, level-type interrupt output.

The host reaches the block through a simple synchronous port. Writes are taken on a clock edge when the write strobe is high. Read data is a combinational function of the address. A write of any value to the reset register starts a software reset of fixed length. While it runs, every enable and status register is held at its default and all host writes are ignored. The length of the reset depends on the host bus style selected at the time of the write, and the pulse is driven out so that the rest of the interface can use it as well. Alarm-indication changes are only seen while host mode is selected.

Top module: `alarm_irq_ctrl`

## Requirements
- R1: Every register holds channel n in bit n (bits 3..0). Bits 7..4 always read 0, and write data in bits 7..4 has no effect.
- R2: A change in either direction of a synchronised raw alarm sets the matching status bit. The status registers are at 0x0C (loss of signal), 0x0D (driver failure) and 0x0E (alarm indication). Each source and channel is independent of the others.
- R3: Writing 1 to a status bit clears it. Writing 0 to a status bit leaves it unchanged.
- R4: When an alarm change and a write-1 clear reach the same status bit on the same clock edge, the bit ends up set.
- R5: The enable registers are read/write and hold 1 to enable a channel. They are at 0x08 (loss of signal), 0x09 (driver failure) and 0x14 (alarm indication).
- R6: irq_no is low while at least one status bit that is also enabled is set. It is high otherwise. The output is registered and follows the registers one cycle later.
- R7: While host_mode_i is low, alarm-indication inputs cause no status change, and the alarm-indication raw register reads 0.
- R8: A write of any data to 0x0A drives sw_rst_o high for RST_SHORT_CYC cycles (200 by default). When nonmux_i is high at the write, it drives sw_rst_o high for RST_LONG_CYC cycles (400 by default).
- R9: While sw_rst_o is high, all enable and status bits are held at 0, irq_no goes high, and host writes are ignored. This includes writes to 0x0A, which do not restart the cycle.
- R10: After rst_ni is released, all registers read 0, irq_no is high and sw_rst_o is low.
- R11: The raw registers at 0x04 (loss of signal), 0x05 (driver failure) and 0x06 (alarm indication) show the synchronised inputs. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_mode_i | input | 1 | High when the interface is under host control; enables alarm-indication detection |
| nonmux_i | input | 1 | High selects the non-multiplexed bus style (long software reset) |
| los_i | input | 4 | Raw loss-of-signal alarm per channel |
| dfm_i | input | 4 | Raw driver-failure alarm per channel |
| ais_i | input | 4 | Raw alarm-indication flag per channel |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i |
| irq_no | output | 1 | Active-low level interrupt |
| sw_rst_o | output | 1 | High during a software reset cycle |

## Verification
The bench drives an alarm change so that the change and a write-1 clear of the same bit land on the same edge. A design that lets the clear win would silently lose an event. The length of the reset pulse is counted in both bus styles. Writes are issued during the pulse, including a second reset request: a design that restarts the timer gives a longer pulse, and a design that accepts writes leaves a nonzero enable. Alarm-indication toggles made while host mode is off must leave no status and read as 0. Writes of all ones to enables show whether bits 7..4 leak into the readback. Random toggling, enabling and clearing across the three sources checks the interrupt level against a bench model. This catches a wrong source index, a level that clears too early, and missed falling-edge changes.

// File: rtl/alarm_irq_pkg.sv
package alarm_irq_pkg;
  localparam int NSRC = 3;
  localparam int AW   = 5;
  localparam int DW   = 8;

  localparam int SRC_LOS = 0;
  localparam int SRC_DFM = 1;
  localparam int SRC_AIS = 2;

  localparam logic [AW-1:0] A_SWRST = 5'h0A;

  function automatic logic [AW-1:0] raw_addr(int s);
    case (s)
      SRC_LOS: return 5'h04;
      SRC_DFM: return 5'h05;
      default: return 5'h06;
    endcase
  endfunction

  function automatic logic [AW-1:0] en_addr(int s);
    case (s)
      SRC_LOS: return 5'h08;
      SRC_DFM: return 5'h09;
      default: return 5'h14;
    endcase
  endfunction

  function automatic logic [AW-1:0] st_addr(int s);
    case (s)
      SRC_LOS: return 5'h0C;
      SRC_DFM: return 5'h0D;
      default: return 5'h0E;
    endcase
  endfunction
endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe <= '0;
    end else begin
      pipe[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/alarm_src.sv
module alarm_src #(
  parameter int NCH  = 4,
  parameter int SYNC = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clr_i,
  input  logic           act_i,
  input  logic [NCH-1:0] raw_i,
  input  logic           en_we_i,
  input  logic           st_clr_i,
  input  logic [NCH-1:0] wdata_i,
  output logic [NCH-1:0] raw_o,
  output logic [NCH-1:0] en_o,
  output logic [NCH-1:0] st_o
);
  logic [NCH-1:0] sync_q, qual, prev_q, evt, clr_mask;

  alarm_sync #(.W(NCH), .STAGES(SYNC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(raw_i), .q_o(sync_q)
  );

  assign qual     = sync_q & {NCH{act_i}};
  assign evt      = qual ^ prev_q;
  assign clr_mask = st_clr_i ? wdata_i : '0;

  // prev keeps tracking during a soft reset so no stale change fires after it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= qual;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      en_o <= '0;
    else if (clr_i)   en_o <= '0;
    else if (en_we_i) en_o <= wdata_i;
  end

  // new change wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    st_o <= '0;
    else if (clr_i) st_o <= '0;
    else            st_o <= (st_o & ~clr_mask) | evt;
  end

  assign raw_o = qual;
endmodule

// File: rtl/sw_reset_timer.sv
module sw_reset_timer #(
  parameter int SHORT_CYC = 200,
  parameter int LONG_CYC  = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic long_i,
  output logic busy_o
);
  localparam int CW = $clog2(LONG_CYC + 1);
  localparam logic [CW-1:0] SHORT_V = CW'(SHORT_CYC);
  localparam logic [CW-1:0] LONG_V  = CW'(LONG_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (start_i && !busy_o)    cnt_q <= long_i ? LONG_V : SHORT_V;
    else if (busy_o)                cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl
  import alarm_irq_pkg::*;
#(
  parameter int NCH           = 4,
  parameter int SYNC_STAGES   = 2,
  parameter int RST_SHORT_CYC = 200,
  parameter int RST_LONG_CYC  = 400
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          host_mode_i,
  input  logic          nonmux_i,
  input  logic [NCH-1:0] los_i,
  input  logic [NCH-1:0] dfm_i,
  input  logic [NCH-1:0] ais_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output logic          irq_no,
  output logic          sw_rst_o
);
  logic                           wr_ok, rst_hit, pend_any;
  logic [NSRC-1:0][NCH-1:0]       raw_in, raw_all, en_all, st_all;

  assign raw_in[SRC_LOS] = los_i;
  assign raw_in[SRC_DFM] = dfm_i;
  assign raw_in[SRC_AIS] = ais_i;

  assign wr_ok   = we_i && !sw_rst_o;
  assign rst_hit = wr_ok && (addr_i == A_SWRST);

  sw_reset_timer #(.SHORT_CYC(RST_SHORT_CYC), .LONG_CYC(RST_LONG_CYC)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(rst_hit),
    .long_i(nonmux_i), .busy_o(sw_rst_o)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    alarm_src #(.NCH(NCH), .SYNC(SYNC_STAGES)) u_src (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (sw_rst_o),
      .act_i   ((s == SRC_AIS) ? host_mode_i : 1'b1),
      .raw_i   (raw_in[s]),
      .en_we_i (wr_ok && (addr_i == en_addr(s))),
      .st_clr_i(wr_ok && (addr_i == st_addr(s))),
      .wdata_i (wdata_i[NCH-1:0]),
      .raw_o   (raw_all[s]),
      .en_o    (en_all[s]),
      .st_o    (st_all[s])
    );
  end

  always_comb begin
    rdata_o = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (addr_i == raw_addr(s)) rdata_o[NCH-1:0] = raw_all[s];
      if (addr_i == en_addr(s))  rdata_o[NCH-1:0] = en_all[s];
      if (addr_i == st_addr(s))  rdata_o[NCH-1:0] = st_all[s];
    end
  end

  assign pend_any = |(st_all & en_all);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= !pend_any;
  end
endmodule

// File: rtl/alarm_irq_ctrl_chk.sv
module alarm_irq_ctrl_chk
  import alarm_irq_pkg::*;
#(
  parameter int NCH           = 4,
  parameter int RST_SHORT_CYC = 200,
  parameter int RST_LONG_CYC  = 400
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     we_i,
  input logic                     nonmux_i,
  input logic [AW-1:0]            addr_i,
  input logic [DW-1:0]            rdata_o,
  input logic                     irq_no,
  input logic                     sw_rst_o,
  input logic [NSRC-1:0][NCH-1:0] st_all,
  input logic [NSRC-1:0][NCH-1:0] en_all
);
  localparam int HW = $clog2(RST_LONG_CYC + 2);
  logic [HW-1:0] hi_cnt, exp_len;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt  <= '0;
      exp_len <= '0;
    end else begin
      hi_cnt <= sw_rst_o ? hi_cnt + 1'b1 : '0;
      if (we_i && !sw_rst_o && addr_i == A_SWRST)
        exp_len <= nonmux_i ? HW'(RST_LONG_CYC) : HW'(RST_SHORT_CYC);
    end
  end

  a_r1_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rdata_o[DW-1:NCH] == '0);

  a_r6_irq_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(st_all & en_all)) |=> !irq_no);

  a_r6_irq_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(st_all & en_all)) |=> irq_no);

  a_r8_pulse_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_rst_o) |-> hi_cnt == exp_len);

  a_r9_regs_cleared: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rst_o && $past(sw_rst_o)) |-> (st_all == '0 && en_all == '0));

  a_r9_irq_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_rst_o && $past(sw_rst_o)) |=> irq_no);
endmodule

bind alarm_irq_ctrl alarm_irq_ctrl_chk #(
  .NCH(NCH), .RST_SHORT_CYC(RST_SHORT_CYC), .RST_LONG_CYC(RST_LONG_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .nonmux_i(nonmux_i),
  .addr_i(addr_i), .rdata_o(rdata_o), .irq_no(irq_no), .sw_rst_o(sw_rst_o),
  .st_all(st_all), .en_all(en_all)
);

// File: tb/alarm_irq_ctrl_tb.sv
`timescale 1ns/1ps
module alarm_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       host = 1'b1;
  logic       nonmux = 1'b0;
  logic [3:0] los_r = '0, dfm_r = '0, ais_r = '0;
  logic       we_r = 1'b0;
  logic [4:0] addr_r = '0;
  logic [7:0] wdata_r = '0;
  logic [7:0] rdata;
  logic       irq_n, swrst;

  int n_chk = 0, n_err = 0;
  logic [3:0] m_raw [3];
  logic [3:0] m_en  [3];
  logic [3:0] m_st  [3];

  always #2.5 clk = ~clk;

  alarm_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .host_mode_i(host), .nonmux_i(nonmux),
    .los_i(los_r), .dfm_i(dfm_r), .ais_i(ais_r), .we_i(we_r),
    .addr_i(addr_r), .wdata_i(wdata_r), .rdata_o(rdata),
    .irq_no(irq_n), .sw_rst_o(swrst)
  );

  function automatic logic [4:0] a_raw(int s); return (s == 0) ? 5'h04 : (s == 1) ? 5'h05 : 5'h06; endfunction
  function automatic logic [4:0] a_en(int s);  return (s == 0) ? 5'h08 : (s == 1) ? 5'h09 : 5'h14; endfunction
  function automatic logic [4:0] a_st(int s);  return (s == 0) ? 5'h0C : (s == 1) ? 5'h0D : 5'h0E; endfunction

  function automatic logic [3:0] qual(int s);
    return (s == 2 && !host) ? 4'h0 : m_raw[s];
  endfunction

  function automatic logic [7:0] exp_rd(logic [4:0] a);
    for (int s = 0; s < 3; s++) begin
      if (a == a_raw(s)) return {4'h0, qual(s)};
      if (a == a_en(s))  return {4'h0, m_en[s]};
      if (a == a_st(s))  return {4'h0, m_st[s]};
    end
    return 8'h00;
  endfunction

  function automatic logic exp_irq();
    logic p = 1'b0;
    for (int s = 0; s < 3; s++) p |= |(m_st[s] & m_en[s]);
    return !p;
  endfunction

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    addr_r = a; #1; d = rdata;
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    we_r = 1'b1; addr_r = a; wdata_r = d;
    @(posedge clk); @(negedge clk);
    we_r = 1'b0;
  endtask

  task automatic wr_m(logic [4:0] a, logic [7:0] d);
    wr(a, d);
    for (int s = 0; s < 3; s++) begin
      if (a == a_en(s)) m_en[s] = d[3:0];
      if (a == a_st(s)) m_st[s] &= ~d[3:0];
    end
    tick(2);
  endtask

  task automatic drive_raw(int s, logic [3:0] v);
    case (s)
      0: los_r = v;
      1: dfm_r = v;
      default: ais_r = v;
    endcase
  endtask

  task automatic set_raw(int s, logic [3:0] v);
    logic [3:0] o = qual(s);
    drive_raw(s, v);
    m_raw[s] = v;
    tick(5);
    m_st[s] |= o ^ qual(s);
  endtask

  task automatic set_host(logic h);
    logic [3:0] o = qual(2);
    host = h;
    tick(5);
    m_st[2] |= o ^ qual(2);
  endtask

  task automatic check_all(string tag);
    logic [7:0] d;
    logic [4:0] al [10] = '{5'h04, 5'h05, 5'h06, 5'h08, 5'h09, 5'h14, 5'h0C, 5'h0D, 5'h0E, 5'h1F};
    foreach (al[i]) begin
      rd(al[i], d);
      chk(tag, {8'h0, d}, {8'h0, exp_rd(al[i])});
    end
    chk({tag, " irq R6"}, {15'h0, irq_n}, {15'h0, exp_irq()});
  endtask

  initial begin
    #(200000 * 5);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cnt;
    void'($urandom(32'h5eed_0386));
    for (int s = 0; s < 3; s++) begin m_raw[s] = '0; m_en[s] = '0; m_st[s] = '0; end
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R10 reset state
    check_all("R10 reset");
    chk("R10 swrst", {15'h0, swrst}, 16'h0);

    // R1 upper bits
    wr_m(a_en(0), 8'hFF);
    rd(a_en(0), d);
    chk("R1 upper bits", {8'h0, d}, 16'h000F);
    wr_m(a_en(0), 8'h00);

    // R11 / R2 each source, both edges
    for (int s = 0; s < 3; s++) begin
      set_raw(s, 4'hA);
      check_all("R11/R2 rise");
      wr_m(a_st(s), 8'hFF);
      set_raw(s, 4'h0);
      check_all("R2 fall");
      wr_m(a_st(s), 8'h05);
      check_all("R3 partial clear");
      wr_m(a_st(s), 8'h0A);
    end

    // R5/R6 enable drives irq
    set_raw(1, 4'h4);
    check_all("R6 disabled");
    wr_m(a_en(1), 8'h04);
    check_all("R5/R6 enabled");
    wr_m(a_st(1), 8'h04);
    check_all("R6 released");

    // R4 change and clear on the same edge
    drive_raw(0, m_raw[0] ^ 4'h1);
    tick(2);
    we_r = 1'b1; addr_r = a_st(0); wdata_r = 8'h01;
    @(negedge clk);
    we_r = 1'b0;
    m_raw[0] ^= 4'h1;
    m_st[0] |= 4'h1;
    tick(3);
    rd(a_st(0), d);
    chk("R4 set wins", {8'h0, d}, {8'h0, exp_rd(a_st(0))});

    // R7 host mode off
    wr_m(a_st(2), 8'h0F);
    set_host(1'b0);
    set_raw(2, 4'hF);
    check_all("R7 host off high");
    rd(5'h06, d);
    chk("R7 raw reads 0", {8'h0, d}, 16'h0);
    set_raw(2, 4'h0);
    check_all("R7 host off low");
    set_host(1'b1);

    // random mix
    for (int it = 0; it < 500; it++) begin
      int s = $urandom % 3;
      case ($urandom % 4)
        0: set_raw(s, 4'($urandom));
        1: wr_m(a_en(s), 8'($urandom));
        2: wr_m(a_st(s), 8'($urandom));
        default: check_all("R2/R3/R5 random");
      endcase
      chk("R6 random irq", {15'h0, irq_n}, {15'h0, exp_irq()});
    end

    // R8 short reset
    nonmux = 1'b0;
    wr(5'h0A, 8'h5A);
    cnt = 0;
    while (swrst) begin cnt++; @(negedge clk); end
    chk("R8 short len", 16'(cnt), 16'd200);
    for (int s = 0; s < 3; s++) begin m_en[s] = '0; m_st[s] = '0; end
    check_all("R9 after short");

    // R8/R9 long reset with writes during it
    wr_m(a_en(0), 8'h0F);
    set_raw(0, m_raw[0] ^ 4'h3);
    check_all("R6 before reset");
    nonmux = 1'b1;
    wr(5'h0A, 8'h00);
    nonmux = 1'b0;
    cnt = 0;
    while (swrst) begin
      cnt++;
      if (cnt == 5) chk("R9 irq high", {15'h0, irq_n}, 16'h1);
      if (cnt == 10) begin we_r = 1'b1; addr_r = a_en(1); wdata_r = 8'h0F; end
      else if (cnt == 11) begin we_r = 1'b1; addr_r = 5'h0A; wdata_r = 8'h00; end
      else we_r = 1'b0;
      @(negedge clk);
      if (cnt > 1000) break;
    end
    we_r = 1'b0;
    chk("R8 long len", 16'(cnt), 16'd400);
    for (int s = 0; s < 3; s++) begin m_en[s] = '0; m_st[s] = '0; end
    tick(2);
    check_all("R9 after long");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule